// File: doc/BRIEF.md
# Streaming TLP Receive Front End

This block sits behind a 128-bit valid/ready streaming sink that delivers PCI Express transaction-layer packets. Each packet is marked with start and end flags. A one-bit empty flag qualifies the final beat. Every packet in scope opens with a beat holding a complete four-dword header with a qword-aligned address. The block lifts that header onto a dedicated header port with its own handshake. It forwards the remaining beats unchanged on a separate payload stream, which carries its own start, end and empty flags.

The sender reacts to ready late. It may present up to three more beats after ready falls. For that reason every beat presented with valid high is written into a skid FIFO. Ready to the sender stays high only while the FIFO has more than three free entries.

A two-state framing machine sits in front of the FIFO. In FR_IDLE, a start beat moves it to FR_PKT unless that beat also ends the packet. In FR_PKT, an end beat returns it to FR_IDLE. The framing machine drops beats that belong to no packet.

A three-state split machine sits behind the FIFO:
- SP_HDR offers the head beat as the header.
- After the header is accepted, the machine goes to SP_PL_FIRST, or stays in SP_HDR if the header beat also ended the packet.
- SP_PL_FIRST offers the first payload beat and moves to SP_PL_REST.
- Both payload states return to SP_HDR on an accepted end beat.
- Both payload states also return to SP_HDR without consuming anything if a new start beat reaches the head. This is the resync transition.

Top module: `tlp_rx_front`

## Requirements
- R1: Reset empties the FIFO, puts both machines in their idle states and clears the error flag. After reset, in_ready=1, hdr_valid=0, pl_valid=0 and proto_err=0.
- R2: The start beat of a packet appears on hdr_data unchanged. Header dword k is in bits [32k+31:32k] for k=0..3.
- R3: The beats after the start beat appear on the payload port in arrival order with unchanged data. pl_sop=1 only on the first payload beat, and pl_eop=1 only on the packet's end beat.
- R4: pl_empty repeats the empty flag of each payload beat. empty=1 on an end beat means only bits [63:0] are valid. empty=0 means all 128 bits are valid.
- R5: in_ready is 1 exactly while more than three FIFO entries are free. Every beat presented with in_valid=1 is captured, including up to three beats that arrive after in_ready falls. No beat is lost.
- R6: A cycle with in_valid=0 captures nothing, whatever the sop, eop and data inputs show.
- R7: Packets whose start beat directly follows the previous end beat are split correctly.
- R8: A packet whose start beat is also its end beat yields one header and no payload beats.
- R9: No payload beat of a packet is offered before that packet's header has been accepted. While hdr_valid=1 and hdr_ready=0, the header stays valid and unchanged.
- R10: A beat arriving outside a packet without sop is dropped. If it carries eop, proto_err rises on the next cycle and stays at 1 until reset.
- R11: While pl_valid=1 and pl_ready=0, the payload beat stays valid and unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Application clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat is valid |
| in_ready | output | 1 | Sender may keep sending (takes effect up to three cycles late) |
| in_data | input | 128 | Input beat data |
| in_sop | input | 1 | First beat of a packet |
| in_eop | input | 1 | Last beat of a packet |
| in_empty | input | 1 | Upper 64 bits of the last beat are unused |
| hdr_valid | output | 1 | Header available |
| hdr_ready | input | 1 | Header consumer ready |
| hdr_data | output | 128 | Four-dword header |
| pl_valid | output | 1 | Payload beat available |
| pl_ready | input | 1 | Payload consumer ready |
| pl_data | output | 128 | Payload beat data |
| pl_sop | output | 1 | First payload beat |
| pl_eop | output | 1 | Last payload beat |
| pl_empty | output | 1 | Upper 64 bits of the last payload beat are unused |
| proto_err | output | 1 | Sticky flag for an end beat seen outside a packet |

## Verification
The in-RTL assertions check several properties on every cycle:
- the FIFO never overflows or underflows;
- the sender never sends later than its three-cycle window;
- header and payload are never offered together, and each is held stable while stalled;
- the split machine only offers start beats as headers;
- the error flag, once set, stays set.

Only the bench scenarios can show the rest:
- the dword mapping and the unchanged data;
- the exact order and framing of payload beats;
- empty pass-through and header-only packets;
- that no beat is lost under every sender lag from zero to three cycles, combined with downstream stalls;
- that valid-low cycles and orphan beats produce no output.

// File: rtl/tlp_rx_pkg.sv
package tlp_rx_pkg;

    localparam int unsigned BEAT_W = 128;

    typedef struct packed {
        logic [BEAT_W-1:0] data;
        logic              sop;
        logic              eop;
        logic              empty;
    } beat_t;

    typedef enum logic {
        FR_IDLE,
        FR_PKT
    } frame_state_e;

    typedef enum logic [1:0] {
        SP_HDR,
        SP_PL_FIRST,
        SP_PL_REST
    } split_state_e;

endpackage

// File: rtl/tlp_rx_frame_filter.sv
module tlp_rx_frame_filter
    import tlp_rx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_sop,
    input  logic in_eop,
    output logic keep,
    output logic err
);

    frame_state_e state_q, state_d;
    logic         err_q, err_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FR_IDLE;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            err_q   <= err_d;
        end
    end

    always_comb begin
        state_d = state_q;
        err_d   = err_q;
        keep    = 1'b0;
        unique case (state_q)
            FR_IDLE: begin
                if (in_valid && in_sop) begin
                    keep = 1'b1;
                    if (!in_eop) state_d = FR_PKT;
                end else if (in_valid && in_eop) begin
                    err_d = 1'b1;
                end
            end
            FR_PKT: begin
                if (in_valid) begin
                    keep = 1'b1;
                    if (in_eop) state_d = FR_IDLE;
                end
            end
            default: state_d = FR_IDLE;
        endcase
    end

    assign err = err_q;

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    // R6
    idle_no_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> !keep);

endmodule

// File: rtl/tlp_rx_skid_fifo.sv
module tlp_rx_skid_fifo
    import tlp_rx_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  beat_t         push_beat,
    input  logic          pop,
    output beat_t         head,
    output logic          head_valid,
    output logic [CW-1:0] free_cnt
);

    beat_t         mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_beat;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign head       = mem[rd_ptr];
    assign head_valid = (count != '0);
    assign free_cnt   = CW'(DEPTH) - count;

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (free_cnt != '0 || pop));

    // R5
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> head_valid);

endmodule

// File: rtl/tlp_rx_split.sv
module tlp_rx_split
    import tlp_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  beat_t             head,
    input  logic              head_valid,
    output logic              pop,
    output logic              hdr_valid,
    input  logic              hdr_ready,
    output logic [BEAT_W-1:0] hdr_data,
    output logic              pl_valid,
    input  logic              pl_ready,
    output logic [BEAT_W-1:0] pl_data,
    output logic              pl_sop,
    output logic              pl_eop,
    output logic              pl_empty
);

    split_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SP_HDR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d   = state_q;
        pop       = 1'b0;
        hdr_valid = 1'b0;
        pl_valid  = 1'b0;
        pl_sop    = 1'b0;
        unique case (state_q)
            SP_HDR: begin
                hdr_valid = head_valid;
                if (head_valid && hdr_ready) begin
                    pop = 1'b1;
                    if (!head.eop) state_d = SP_PL_FIRST;
                end
            end
            SP_PL_FIRST, SP_PL_REST: begin
                if (head_valid && head.sop) begin
                    state_d = SP_HDR;
                end else begin
                    pl_valid = head_valid;
                    pl_sop   = (state_q == SP_PL_FIRST);
                    if (head_valid && pl_ready) begin
                        pop     = 1'b1;
                        state_d = head.eop ? SP_HDR : SP_PL_REST;
                    end
                end
            end
            default: state_d = SP_HDR;
        endcase
    end

    assign hdr_data = head.data;
    assign pl_data  = head.data;
    assign pl_eop   = head.eop;
    assign pl_empty = head.empty;

    // R9
    hdr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hdr_valid && pl_valid));

    // R9
    hdr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && !hdr_ready) |=> (hdr_valid && $stable(hdr_data)));

    // R11
    pl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pl_valid && !pl_ready) |=> (pl_valid && $stable(pl_data) && $stable(pl_eop)));

    // R2
    hdr_is_sop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |-> head.sop);

endmodule

// File: rtl/tlp_rx_front.sv
module tlp_rx_front
    import tlp_rx_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned LAG   = 3,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BEAT_W-1:0] in_data,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic              in_empty,
    output logic              hdr_valid,
    input  logic              hdr_ready,
    output logic [BEAT_W-1:0] hdr_data,
    output logic              pl_valid,
    input  logic              pl_ready,
    output logic [BEAT_W-1:0] pl_data,
    output logic              pl_sop,
    output logic              pl_eop,
    output logic              pl_empty,
    output logic              proto_err
);

    logic          keep, pop, head_valid;
    beat_t         in_beat, head;
    logic [CW-1:0] free_cnt;

    assign in_beat = '{data: in_data, sop: in_sop, eop: in_eop, empty: in_empty};

    tlp_rx_frame_filter u_filter (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_sop   (in_sop),
        .in_eop   (in_eop),
        .keep     (keep),
        .err      (proto_err)
    );

    tlp_rx_skid_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (keep),
        .push_beat  (in_beat),
        .pop        (pop),
        .head       (head),
        .head_valid (head_valid),
        .free_cnt   (free_cnt)
    );

    tlp_rx_split u_split (
        .clk        (clk),
        .rst_n      (rst_n),
        .head       (head),
        .head_valid (head_valid),
        .pop        (pop),
        .hdr_valid  (hdr_valid),
        .hdr_ready  (hdr_ready),
        .hdr_data   (hdr_data),
        .pl_valid   (pl_valid),
        .pl_ready   (pl_ready),
        .pl_data    (pl_data),
        .pl_sop     (pl_sop),
        .pl_eop     (pl_eop),
        .pl_empty   (pl_empty)
    );

    assign in_ready = (free_cnt > CW'(LAG));

    // Cycles spent with ready low, saturating; guards the sender's lag window.
    logic [CW-1:0] low_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n)                      low_cnt <= '0;
        else if (in_ready)               low_cnt <= '0;
        else if (low_cnt != CW'(LAG))    low_cnt <= low_cnt + 1'b1;
    end

    // R5
    upstream_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ready && low_cnt == CW'(LAG)) |-> !in_valid);

    // R5
    depth_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        DEPTH > LAG);

endmodule

// File: tb/tlp_rx_front_bench.sv
module tlp_rx_front_bench;
    import tlp_rx_pkg::*;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic         rst_n, in_valid, in_ready, in_sop, in_eop, in_empty;
    logic [127:0] in_data, hdr_data, pl_data;
    logic         hdr_valid, hdr_ready, pl_valid, pl_ready, pl_sop, pl_eop, pl_empty, proto_err;

    tlp_rx_front u_tlp_rx_front (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop), .in_empty(in_empty),
        .hdr_valid(hdr_valid), .hdr_ready(hdr_ready), .hdr_data(hdr_data),
        .pl_valid(pl_valid), .pl_ready(pl_ready), .pl_data(pl_data),
        .pl_sop(pl_sop), .pl_eop(pl_eop), .pl_empty(pl_empty), .proto_err(proto_err)
    );

    int n_chk = 0, n_fail = 0, cyc = 0, lowcnt = 0, hdr_done = 0;
    bit timed_out = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic [130:0] src[$];
    logic [127:0] exp_hdr[$];
    logic [130:0] exp_pl[$];
    int exp_pl_pkt[$];
    logic         prev_hstall = 0, prev_pstall = 0;
    logic [127:0] prev_hdata, prev_pdata;

    task automatic chk(bit ok, string req, logic [130:0] act, logic [130:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] mkdata(int pkt, int beat);
        logic [127:0] d;
        for (int dw = 0; dw < 4; dw++) d[32*dw +: 32] = {pkt[15:0], beat[7:0], dw[7:0]};
        return d;
    endfunction

    task automatic add_pkt(int id, int plen, bit emp);
        logic [127:0] h = mkdata(id, 255);
        src.push_back({h, 1'b1, plen == 0, 1'b0});
        exp_hdr.push_back(h);
        for (int i = 0; i < plen; i++) begin
            logic last = (i == plen - 1);
            logic [127:0] d = mkdata(id, i);
            src.push_back({d, 1'b0, last, last & emp});
            exp_pl.push_back({d, i == 0, last, last & emp});
            exp_pl_pkt.push_back(id);
        end
    endtask

    task automatic step(int lag, int mode);
        @(negedge clk);
        cyc++;
        if (cyc > 150000) timed_out = 1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        hdr_ready = (mode == 0) ? 1'b1 : (mode == 1) ? lfsr[0] : (lfsr[0] & lfsr[3]);
        pl_ready  = (mode == 0) ? 1'b1 : (mode == 1) ? lfsr[7] : (lfsr[7] & lfsr[9]);
        if (in_ready) lowcnt = 0; else lowcnt++;
        if (src.size() > 0 && lowcnt <= lag && !(mode == 2 && lfsr[5] && lfsr[11])) begin
            {in_data, in_sop, in_eop, in_empty} = src.pop_front();
            in_valid = 1'b1;
        end else begin
            // R6: garbage framing with valid low must be ignored
            in_valid = 1'b0;
            in_data  = {8{lfsr}};
            in_sop   = 1'b1;
            in_eop   = lfsr[2];
            in_empty = lfsr[4];
        end
        #1;
        if (prev_hstall) chk(hdr_valid && hdr_data == prev_hdata, "R9 header hold", {3'b0, hdr_data}, {3'b0, prev_hdata});
        if (prev_pstall) chk(pl_valid && pl_data == prev_pdata, "R11 payload hold", {3'b0, pl_data}, {3'b0, prev_pdata});
        prev_hstall = hdr_valid && !hdr_ready; prev_hdata = hdr_data;
        prev_pstall = pl_valid && !pl_ready;   prev_pdata = pl_data;
        if (hdr_valid && hdr_ready) begin
            if (exp_hdr.size() == 0) chk(0, "R6 unexpected header", {3'b0, hdr_data}, '0);
            else begin
                logic [127:0] e = exp_hdr.pop_front();
                chk(hdr_data == e, "R2 header dwords", {3'b0, hdr_data}, {3'b0, e});
                hdr_done++;
            end
        end
        if (pl_valid && pl_ready) begin
            if (exp_pl.size() == 0) chk(0, "R8 unexpected payload", {pl_data, pl_sop, pl_eop, pl_empty}, '0);
            else begin
                logic [130:0] e = exp_pl.pop_front();
                int pk = exp_pl_pkt.pop_front();
                chk(pk < hdr_done, "R9 payload before header", pk, hdr_done);
                chk({pl_data, pl_sop, pl_eop} == e[130:1], "R3 payload beat",
                    {pl_data, pl_sop, pl_eop, pl_empty}, e);
                chk(pl_empty == e[0], "R4 empty pass", pl_empty, e[0]);
            end
        end
    endtask

    initial begin
        int id = 0;
        rst_n = 0; in_valid = 0; in_data = '0; in_sop = 0; in_eop = 0; in_empty = 0;
        hdr_ready = 0; pl_ready = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        chk(in_ready && !hdr_valid && !pl_valid && !proto_err, "R1 reset state",
            {in_ready, hdr_valid, pl_valid, proto_err}, 4'b1000);
        for (int mode = 0; mode < 3 && !timed_out; mode++)
            for (int lag = 0; lag < 4 && !timed_out; lag++) begin
                // R7 back-to-back packets, R8 header-only packets (plen 0)
                for (int plen = 0; plen < 5; plen++)
                    for (int emp = 0; emp < 2; emp++) begin
                        add_pkt(id, plen, (plen > 0) && emp[0]);
                        id++;
                    end
                while (!timed_out && (src.size() > 0 || exp_hdr.size() > 0 || exp_pl.size() > 0))
                    step(lag, mode);
                chk(exp_hdr.size() == 0 && exp_pl.size() == 0, "R5 R7 all beats delivered",
                    exp_hdr.size() + exp_pl.size(), 0);
            end
        // R10: orphan middle beat, then orphan end beat
        @(negedge clk);
        in_valid = 1; in_sop = 0; in_eop = 0; in_data = '1;
        @(negedge clk);
        in_valid = 0;
        #1;
        chk(!proto_err && !hdr_valid && !pl_valid, "R10 orphan middle dropped",
            {proto_err, hdr_valid, pl_valid}, 3'b000);
        @(negedge clk);
        in_valid = 1; in_sop = 0; in_eop = 1;
        @(negedge clk);
        in_valid = 0;
        #1;
        chk(proto_err && !hdr_valid && !pl_valid, "R10 orphan end flagged",
            {proto_err, hdr_valid, pl_valid}, 3'b100);
        repeat (5) @(negedge clk);
        #1;
        chk(proto_err, "R10 flag sticky", proto_err, 1);
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        #1;
        chk(!proto_err && in_ready, "R1 reset clears flag", {proto_err, in_ready}, 2'b01);
        if (timed_out) chk(0, "R5 watchdog expired", cyc, 150000);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule